// File: doc/BRIEF.md
# PIO Sector Data-Out Sequencer

This block delivers the result of a disk read to the host one byte at a time. Each host read of the data port takes one byte out of a local sector buffer. The host sets the transfer length with a load request. The block keeps the byte pointer and raises an interrupt request each time a programmed multiple-sector block has been consumed. At the final byte it closes the transfer by updating the status and the sector-count (interrupt reason) registers.

The sector buffer is a byte RAM with a synchronous read port and a fill port for the storage side. A host byte read is accepted on a clock edge. Its byte, its interrupt request and any status change all appear on the outputs after that same edge. The host programs the block size by writing the sector-count register and then issuing a set-multiple request. A device-reset request abandons any transfer in progress.

Top module: `pio_dout_seq`

## Requirements
- R1: After reset, status reads 0x50, the sector-count register reads 0x00, irq_req and rd_valid are low, and the block size is one sector.
- R2: A load with a non-zero length sets status to 0x58 one cycle later. A load with length zero leaves status at 0x50.
- R3: Each accepted data read returns, one cycle later with rd_valid high, the buffer byte at the current pointer, then advances the pointer by one. The pointer starts at 0 after a load.
- R4: An interrupt pulse is raised when the byte just returned completes a block of N x 512 bytes, counted from the load, where N is the sectors-per-interrupt setting.
- R5: When the last byte of the transfer is returned, irq_req pulses, status becomes 0x50 and the sector-count register becomes 3, all in the cycle that byte is presented.
- R6: A data read after the transfer is exhausted returns 0x00 with rd_valid high, raises no interrupt, and leaves status and the sector-count register unchanged.
- R7: A set-multiple request copies the sector-count register value into the sectors-per-interrupt setting. A value of 0 is taken as 1.
- R8: A device-reset request empties the transfer, returns status to 0x50 and pulses irq_req one cycle later. Later data reads return 0x00.
- R9: A load during a transfer restarts the pointer at 0 with the new length. The new length must not exceed the buffer depth.
- R10: A host write of the sector-count register is visible on sec_count one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Buffer write enable from the storage side |
| fill_addr | input | 10 | Buffer write address |
| fill_data | input | 8 | Buffer write byte |
| load_req | input | 1 | Start a transfer of load_len bytes |
| load_len | input | 11 | Transfer length in bytes |
| data_rd | input | 1 | Host read strobe of the data port, one per byte |
| cnt_wr | input | 1 | Host write of the sector-count register |
| cnt_wdata | input | 8 | Sector-count write value |
| set_mult | input | 1 | Take the sector-count value as sectors per interrupt |
| dev_rst | input | 1 | Device-reset request |
| rd_data | output | 8 | Byte returned for the last data read |
| rd_valid | output | 1 | rd_data holds the answer to a read accepted on the previous edge |
| irq_req | output | 1 | One-cycle interrupt raise request |
| status | output | 8 | Status register value |
| sec_count | output | 8 | Sector-count / interrupt-reason register value |

## Verification
A table of transfers pairs lengths with block settings, and every byte, interrupt and closing status is predicted from first principles. Two cases separate boundary interrupts from last-byte interrupts: a length that is an exact multiple of the block, and one that ends partway through a block. Settings of 1, 2, 3 and 0 check that the block size really scales the interrupt spacing and that zero falls back to one sector. Directed cases cover a zero-length load, reads past the end, a reload in the middle of a transfer, and a device reset in the middle of a transfer, where only the reset path may produce the interrupt.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
   localparam logic [7:0] ST_IDLE     = 8'h50;  // ready, seek complete
   localparam logic [7:0] ST_DRQ      = 8'h58;  // ready, seek complete, data request
   localparam logic [7:0] REASON_DONE = 8'd3;   // interrupt reason after the last byte
endpackage

// File: rtl/pio_buf_ram.sv
module pio_buf_ram #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pio_blk_tracker.sv
module pio_blk_tracker #(
   parameter int SPD_W     = 8,
   parameter int SEC_SHIFT = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_mult,
   input  logic [SPD_W-1:0] cnt_val,
   input  logic             clear,
   input  logic             step,
   output logic             blk_hit
);
   localparam int BLK_W = SPD_W + SEC_SHIFT;

   logic [SPD_W-1:0] spd_q;
   logic [BLK_W-1:0] blk_q;
   logic [BLK_W-1:0] blk_lim;

   // last byte index of one multiple-sector block
   assign blk_lim = {spd_q, {SEC_SHIFT{1'b0}}} - BLK_W'(1);
   assign blk_hit = (blk_q == blk_lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spd_q <= SPD_W'(1);
      end else if (set_mult) begin
         spd_q <= (cnt_val == '0) ? SPD_W'(1) : cnt_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         blk_q <= '0;
      end else if (step) begin
         blk_q <= blk_hit ? '0 : blk_q + BLK_W'(1);
      end
   end

   // R4: a completed block wraps the byte counter back to zero
   p_blk_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && blk_hit && !clear) |=> (blk_q == '0));
endmodule

// File: rtl/pio_xfer_ctl.sv
module pio_xfer_ctl
   import pio_seq_pkg::*;
#(
   parameter int LEN_W = 11,
   parameter int AW    = 10,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_req,
   input  logic [LEN_W-1:0] load_len,
   input  logic             data_rd,
   input  logic             dev_rst,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             blk_hit,
   output logic             rd_go,
   output logic             step,
   output logic             clear,
   output logic [AW-1:0]    ram_addr,
   output logic             hit_q,
   output logic             rd_valid,
   output logic             irq_req,
   output logic [7:0]       status,
   output logic [CNT_W-1:0] sec_count
);
   localparam int PTR_W = LEN_W + 1;

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_nxt;
   logic [LEN_W-1:0] len_q;
   logic             in_range;
   logic             last;

   // load and reset take the cycle; a strobe in that cycle is dropped
   assign rd_go    = data_rd && !load_req && !dev_rst;
   assign clear    = load_req || dev_rst;
   assign ptr_nxt  = ptr_q + PTR_W'(1);
   assign in_range = ptr_q < PTR_W'(len_q);
   assign last     = in_range && (ptr_nxt == PTR_W'(len_q));
   assign step     = rd_go && in_range;
   assign ram_addr = ptr_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         len_q <= '0;
      end else if (dev_rst) begin
         ptr_q <= '0;
         len_q <= '0;
      end else if (load_req) begin
         ptr_q <= '0;
         len_q <= load_len;
      end else if (rd_go && ptr_q != '1) begin
         ptr_q <= ptr_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         hit_q    <= 1'b0;
         irq_req  <= 1'b0;
      end else begin
         rd_valid <= rd_go;
         hit_q    <= step;
         irq_req  <= dev_rst || (step && (blk_hit || last));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= ST_IDLE;
      end else if (dev_rst) begin
         status <= ST_IDLE;
      end else if (load_req) begin
         status <= (load_len != '0) ? ST_DRQ : ST_IDLE;
      end else if (step && last) begin
         status <= ST_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_count <= '0;
      end else if (cnt_wr) begin
         sec_count <= cnt_wdata;
      end else if (step && last) begin
         sec_count <= CNT_W'(REASON_DONE);
      end
   end

   // R2: a non-empty load raises the data request
   p_load_drq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !dev_rst && load_len != '0) |=> (status == ST_DRQ));
   // R5: the last byte closes the transfer
   p_last_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && last && !cnt_wr) |=> (status == ST_IDLE && sec_count == CNT_W'(REASON_DONE) && irq_req));
   // R6: reads past the end are quiet
   p_exhaust_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && !in_range) |=> (rd_valid && !hit_q && !irq_req));
   // R8: device reset idles and interrupts
   p_devrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst |=> (irq_req && status == ST_IDLE));
endmodule

// File: rtl/pio_dout_seq.sv
module pio_dout_seq #(
   parameter int BUF_AW    = 10,
   parameter int CNT_W     = 8,
   parameter int SEC_SHIFT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [BUF_AW-1:0] fill_addr,
   input  logic [7:0]        fill_data,
   input  logic              load_req,
   input  logic [BUF_AW:0]   load_len,
   input  logic              data_rd,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              set_mult,
   input  logic              dev_rst,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              irq_req,
   output logic [7:0]        status,
   output logic [CNT_W-1:0]  sec_count
);
   localparam int LEN_W = BUF_AW + 1;
   localparam int DEPTH = 1 << BUF_AW;

   generate
      if (BUF_AW < 1 || BUF_AW > 16) begin : g_bad_aw
         $error("BUF_AW out of range");
      end
      if (CNT_W < 1 || SEC_SHIFT < 1) begin : g_bad_blk
         $error("CNT_W and SEC_SHIFT must be positive");
      end
   endgenerate

   logic              rd_go;
   logic              step;
   logic              clear;
   logic              blk_hit;
   logic              hit_q;
   logic [BUF_AW-1:0] ram_addr;
   logic [7:0]        ram_q;

   pio_buf_ram #(.AW(BUF_AW), .DW(8)) u_ram (
      .clk   (clk),
      .we    (fill_en),
      .waddr (fill_addr),
      .wdata (fill_data),
      .re    (rd_go),
      .raddr (ram_addr),
      .rdata (ram_q)
   );

   pio_blk_tracker #(.SPD_W(CNT_W), .SEC_SHIFT(SEC_SHIFT)) u_blk (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mult (set_mult),
      .cnt_val  (sec_count),
      .clear    (clear),
      .step     (step),
      .blk_hit  (blk_hit)
   );

   pio_xfer_ctl #(.LEN_W(LEN_W), .AW(BUF_AW), .CNT_W(CNT_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_req  (load_req),
      .load_len  (load_len),
      .data_rd   (data_rd),
      .dev_rst   (dev_rst),
      .cnt_wr    (cnt_wr),
      .cnt_wdata (cnt_wdata),
      .blk_hit   (blk_hit),
      .rd_go     (rd_go),
      .step      (step),
      .clear     (clear),
      .ram_addr  (ram_addr),
      .hit_q     (hit_q),
      .rd_valid  (rd_valid),
      .irq_req   (irq_req),
      .status    (status),
      .sec_count (sec_count)
   );

   assign rd_data = hit_q ? ram_q : 8'h00;

   // R9: a transfer never reaches past the buffer
   p_len_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |-> (load_len <= LEN_W'(DEPTH)));
   // R10: host count writes land on the register
   p_cnt_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (sec_count == $past(cnt_wdata)));
endmodule

// File: tb/pio_dout_seq_test.sv
module pio_dout_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;
   localparam int NV    = 7;
   // {sectors per interrupt[31:24], length[23:8], expected interrupts[7:0]}
   localparam logic [31:0] VEC [NV] = '{
      {8'd1, 16'd1024, 8'd2},
      {8'd2, 16'd1024, 8'd1},
      {8'd1, 16'd700,  8'd2},
      {8'd0, 16'd600,  8'd2},
      {8'd1, 16'd512,  8'd1},
      {8'd3, 16'd5,    8'd1},
      {8'd2, 16'd1000, 8'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fill_en = 1'b0;
   logic [AW-1:0] fill_addr = '0;
   logic [7:0]    fill_data = '0;
   logic          load_req = 1'b0;
   logic [AW:0]   load_len = '0;
   logic          data_rd = 1'b0;
   logic          cnt_wr = 1'b0;
   logic [7:0]    cnt_wdata = '0;
   logic          set_mult = 1'b0;
   logic          dev_rst = 1'b0;
   logic [7:0]    rd_data;
   logic          rd_valid;
   logic          irq_req;
   logic [7:0]    status;
   logic [7:0]    sec_count;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   pio_dout_seq uut (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_addr(fill_addr),
      .fill_data(fill_data), .load_req(load_req), .load_len(load_len),
      .data_rd(data_rd), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .set_mult(set_mult), .dev_rst(dev_rst), .rd_data(rd_data),
      .rd_valid(rd_valid), .irq_req(irq_req), .status(status),
      .sec_count(sec_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] pat(int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
         end
      end
   end

   task automatic rd_byte(output logic [7:0] d, output logic irq, output logic v);
      @(negedge clk) data_rd = 1'b1;
      @(negedge clk) data_rd = 1'b0;
      d = rd_data; irq = irq_req; v = rd_valid;
   endtask

   task automatic do_load(int len);
      @(negedge clk) begin load_req = 1'b1; load_len = (AW+1)'(len); end
      @(negedge clk) load_req = 1'b0;
   endtask

   task automatic write_cnt(logic [7:0] val);
      @(negedge clk) begin cnt_wr = 1'b1; cnt_wdata = val; end
      @(negedge clk) cnt_wr = 1'b0;
   endtask

   task automatic pulse_mult();
      @(negedge clk) set_mult = 1'b1;
      @(negedge clk) set_mult = 1'b0;
   endtask

   initial begin
      logic [7:0] d;
      logic irq, v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(status == 8'h50, "R1 status", status, 8'h50);
      chk(sec_count == 8'h00, "R1 sec_count", sec_count, 0);
      chk(!irq_req && !rd_valid, "R1 irq/valid", {irq_req, rd_valid}, 0);

      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk) begin fill_en = 1'b1; fill_addr = AW'(a); fill_data = pat(a); end
      end
      @(negedge clk) fill_en = 1'b0;

      // R10: count register write
      write_cnt(8'h21);
      chk(sec_count == 8'h21, "R10 sec_count", sec_count, 8'h21);

      // R2: zero-length load keeps idle status
      do_load(0);
      chk(status == 8'h50, "R2 zero load", status, 8'h50);
      rd_byte(d, irq, v);
      chk(v && d == 8'h00 && !irq, "R6 empty read", {v, irq, d}, 10'h200);

      // table: R3 R4 R5 R7
      for (int k = 0; k < NV; k++) begin
         int spd, len, expi, eff, irqs;
         spd = int'(VEC[k][31:24]); len = int'(VEC[k][23:8]); expi = int'(VEC[k][7:0]);
         eff = (spd == 0) ? 1 : spd;
         write_cnt(8'(spd));
         pulse_mult();
         do_load(len);
         chk(status == 8'h58, "R2 load drq", status, 8'h58);
         irqs = 0;
         for (int i = 0; i < len; i++) begin
            bit exp_irq;
            rd_byte(d, irq, v);
            exp_irq = ((i + 1) % (eff * 512) == 0) || (i == len - 1);
            chk(v && d == pat(i), "R3 data", d, pat(i));
            chk(irq == exp_irq, "R4 irq at byte (R7 block size)", irq, exp_irq);
            if (i < len - 1) chk(status == 8'h58, "R2 status held", status, 8'h58);
            if (irq) irqs++;
         end
         chk(status == 8'h50, "R5 final status", status, 8'h50);
         chk(sec_count == 8'd3, "R5 reason", sec_count, 3);
         chk(irqs == expi, "R4 irq count", irqs, expi);
      end

      // R6: reads past the end
      rd_byte(d, irq, v);
      chk(v && d == 8'h00, "R6 zero data", d, 0);
      chk(!irq && status == 8'h50 && sec_count == 8'd3, "R6 unchanged",
          {irq, status, sec_count}, {1'b0, 8'h50, 8'd3});

      // R9: reload in the middle of a transfer
      write_cnt(8'd1);
      pulse_mult();
      do_load(10);
      for (int i = 0; i < 3; i++) rd_byte(d, irq, v);
      do_load(4);
      chk(status == 8'h58, "R9 reload status", status, 8'h58);
      for (int i = 0; i < 4; i++) begin
         rd_byte(d, irq, v);
         chk(d == pat(i), "R9 restart data", d, pat(i));
         chk(irq == (i == 3), "R9 new last irq", irq, (i == 3));
      end
      chk(status == 8'h50, "R9 done", status, 8'h50);

      // R8: device reset mid-transfer
      do_load(20);
      rd_byte(d, irq, v);
      rd_byte(d, irq, v);
      @(negedge clk) dev_rst = 1'b1;
      @(negedge clk) dev_rst = 1'b0;
      chk(irq_req == 1'b1, "R8 irq", irq_req, 1);
      chk(status == 8'h50, "R8 status", status, 8'h50);
      @(negedge clk);
      chk(irq_req == 1'b0, "R8 single pulse", irq_req, 0);
      rd_byte(d, irq, v);
      chk(d == 8'h00 && !irq, "R8 emptied", {irq, d}, 0);

      // R7: zero setting behaves as one sector
      write_cnt(8'd0);
      pulse_mult();
      do_load(513);
      for (int i = 0; i < 513; i++) begin
         rd_byte(d, irq, v);
         if (i == 511) chk(irq == 1'b1, "R7 zero as one", irq, 1);
      end

      finish_run();
   end
endmodule